// File: doc/BRIEF.md
# Searchable Instruction Queue with Register Scoreboard

This block is a short first-in first-out queue that sits between the decode and execute stages of a two-stage processor. Decode pushes decoded instruction templates into it; execute reads and retires the oldest template. Each template is one of four kinds: add, branch-if-zero, load or store. Alongside the usual push and pop, the queue can be searched by register name. The search reports whether a template still in flight will write that register.

A combinational stall port applies that search to the source registers of a raw instruction. Decode uses it to hold back an instruction whose operands are not yet written. A clear strobe flushes every entry in one cycle and is used when a branch is taken.

Within a cycle the effects are ordered as follows. The head is read first. Dequeue or clear comes next, then the search, then the enqueue. The search therefore does not see an entry that leaves in the same cycle, and it does not see an entry that arrives in the same cycle. This lets producer and consumer run together every cycle.

Top module: `iq_scoreboard`

## Requirements
- R1: After synchronous active-high reset the queue is empty: `head_valid` is 0, `enq_ready` is 1, and neither `srch_hit` nor `chk_stall` is asserted.
- R2: Templates leave in the order they were accepted. The kind, destination and both value fields at the head equal those given at enqueue. Kind codes are: 0 add, 1 branch-if-zero, 2 load, 3 store.
- R3: `srch_hit` is 1 only if a held entry has kind add (0) or load (2) and its destination equals `srch_reg`. Branch (1) and store (3) entries never match.
- R4: The search excludes the head entry in a cycle where a dequeue takes effect. It excludes every entry in a cycle where `clr` is high. It never sees the entry being enqueued in that same cycle.
- R5: `chk_stall` covers a different set of source registers for each `chk_kind`. For add (0) both `chk_rs1` and `chk_rs2` are searched. For branch (1), `chk_rs1` is the condition register and `chk_rs2` the target register, and both are searched. For load (2), only `chk_rs1` (the address register) is searched. For store (3), `chk_rs1` is the value register and `chk_rs2` the address register, and both are searched. A hit on any searched register asserts the stall.
- R6: `clr` empties the whole queue, whatever it holds, by the next cycle.
- R7: When `clr` and an enqueue occur in the same cycle, the queue afterwards holds exactly the new entry.
- R8: `enq_ready` is 1 when the queue is not full after the current cycle's dequeue, or when `clr` is high. An enqueue offered while `enq_ready` is 0 is dropped.
- R9: A dequeue on an empty queue has no effect.
- R10: On a full queue, a dequeue and an enqueue in the same cycle keep the queue full and preserve its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Offer a template |
| enq_kind | input | 2 | Kind of offered template |
| enq_dst | input | 5 | Destination register of offered template |
| enq_opa | input | 32 | First value field (add operand, branch condition, load address, store value) |
| enq_opb | input | 32 | Second value field (add operand, branch target, store address) |
| enq_ready | output | 1 | Offered template will be accepted this cycle |
| head_valid | output | 1 | Head fields are meaningful |
| head_kind | output | 2 | Head template kind |
| head_dst | output | 5 | Head destination register |
| head_opa | output | 32 | Head first value field |
| head_opb | output | 32 | Head second value field |
| deq | input | 1 | Retire the head template |
| clr | input | 1 | Flush all templates |
| srch_reg | input | 5 | Register name to search for |
| srch_hit | output | 1 | A pending writer of `srch_reg` is held |
| chk_kind | input | 2 | Kind of raw instruction to check |
| chk_rs1 | input | 5 | First source register of raw instruction |
| chk_rs2 | input | 5 | Second source register of raw instruction |
| chk_stall | output | 1 | Raw instruction must wait |

## Verification
Several internal faults show up directly at the ports. A stale valid bit or a wrong count produces a spurious `srch_hit` or `chk_stall` in the very next cycle. It also produces a wrong `enq_ready`, or a `head_valid` that stays high after the queue has drained. A pointer fault puts a template out of order at the head on the first wrap, which takes at most two pushes at the default depth. A search that ignores the same-cycle ordering shows a hit in exactly the cycle its entry departs. A clear that is applied after the enqueue loses the new entry one cycle later. The bench sweeps every template kind against all 32 register names, and every stall-check kind against every hit combination.

// File: rtl/iq_pkg.sv
package iq_pkg;
    parameter int RN_W  = 5;
    parameter int VAL_W = 32;

    typedef enum logic [1:0] {
        K_ADD = 2'd0,
        K_BZ  = 2'd1,
        K_LD  = 2'd2,
        K_ST  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [RN_W-1:0]   dst;
        logic [VAL_W-1:0]  opa;
        logic [VAL_W-1:0]  opb;
    } tmpl_t;

    function automatic logic writes_reg(input kind_e k);
        return (k == K_ADD) || (k == K_LD);
    endfunction
endpackage

// File: rtl/iq_match.sv
module iq_match
    import iq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic [DEPTH-1:0] live,
    input  tmpl_t            ent [DEPTH],
    input  logic [RN_W-1:0]  reg_name,
    output logic             hit
);
    logic [DEPTH-1:0] per_ent;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign per_ent[i] = live[i] && writes_reg(ent[i].kind)
                            && (ent[i].dst == reg_name);
    end

    assign hit = |per_ent;
endmodule

// File: rtl/iq_ctrl.sv
module iq_ctrl #(
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [PTR_W-1:0] head_q,
    input  logic [PTR_W-1:0] tail_q,
    input  logic [CNT_W-1:0] count_q,
    input  logic [DEPTH-1:0] valid_q,
    input  logic             enq_valid,
    input  logic             deq,
    input  logic             clr,
    output logic             enq_fire,
    output logic             deq_fire,
    output logic             ready,
    output logic [DEPTH-1:0] live,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] head_d,
    output logic [PTR_W-1:0] tail_d,
    output logic [CNT_W-1:0] count_d,
    output logic [DEPTH-1:0] valid_d
);
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic             empty;
    logic             full;
    logic [DEPTH-1:0] head_oh;

    always_comb begin
        empty    = (count_q == '0);
        full     = (count_q == CNT_W'(DEPTH));
        deq_fire = deq && !empty && !clr;
        ready    = clr || !full || deq_fire;
        enq_fire = enq_valid && ready;
        head_oh  = '0;
        head_oh[head_q] = deq_fire;
        live     = clr ? '0 : (valid_q & ~head_oh);

        head_d   = head_q;
        tail_d   = tail_q;
        count_d  = count_q;
        valid_d  = valid_q;
        if (clr) begin
            head_d  = '0;
            tail_d  = '0;
            count_d = '0;
            valid_d = '0;
        end else if (deq_fire) begin
            valid_d[head_q] = 1'b0;
            head_d  = bump(head_q);
            count_d = count_q - 1'b1;
        end
        wr_ptr = tail_d;
        if (enq_fire) begin
            valid_d[tail_d] = 1'b1;
            tail_d  = bump(tail_d);
            count_d = count_d + 1'b1;
        end
    end
endmodule

// File: rtl/iq_scoreboard.sv
module iq_scoreboard
    import iq_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NPORT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    input  logic [1:0]       enq_kind,
    input  logic [RN_W-1:0]  enq_dst,
    input  logic [VAL_W-1:0] enq_opa,
    input  logic [VAL_W-1:0] enq_opb,
    output logic             enq_ready,
    output logic             head_valid,
    output logic [1:0]       head_kind,
    output logic [RN_W-1:0]  head_dst,
    output logic [VAL_W-1:0] head_opa,
    output logic [VAL_W-1:0] head_opb,
    input  logic             deq,
    input  logic             clr,
    input  logic [RN_W-1:0]  srch_reg,
    output logic             srch_hit,
    input  logic [1:0]       chk_kind,
    input  logic [RN_W-1:0]  chk_rs1,
    input  logic [RN_W-1:0]  chk_rs2,
    output logic             chk_stall
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
        logic [DEPTH-1:0] valid;
    } state_t;

    state_t st_d, st_q;
    tmpl_t  mem_d [DEPTH];
    tmpl_t  mem_q [DEPTH];

    logic             enq_fire, deq_fire, ready;
    logic [DEPTH-1:0] live;
    logic [PTR_W-1:0] wr_ptr, head_n, tail_n;
    logic [CNT_W-1:0] count_n;
    logic [DEPTH-1:0] valid_n;

    iq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .head_q   (st_q.head),
        .tail_q   (st_q.tail),
        .count_q  (st_q.count),
        .valid_q  (st_q.valid),
        .enq_valid(enq_valid),
        .deq      (deq),
        .clr      (clr),
        .enq_fire (enq_fire),
        .deq_fire (deq_fire),
        .ready    (ready),
        .live     (live),
        .wr_ptr   (wr_ptr),
        .head_d   (head_n),
        .tail_d   (tail_n),
        .count_d  (count_n),
        .valid_d  (valid_n)
    );

    // Search ports: 0 = external search, 1 = first source, 2 = second source
    logic [RN_W-1:0]  names [NPORT];
    logic [NPORT-1:0] hits;

    assign names[0] = srch_reg;
    assign names[1] = chk_rs1;
    assign names[2] = chk_rs2;

    for (genvar p = 0; p < NPORT; p++) begin : g_srch
        iq_match #(.DEPTH(DEPTH)) u_match (
            .live    (live),
            .ent     (mem_q),
            .reg_name(names[p]),
            .hit     (hits[p])
        );
    end

    always_comb begin
        st_d.head  = head_n;
        st_d.tail  = tail_n;
        st_d.count = count_n;
        st_d.valid = valid_n;
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (enq_fire) begin
            mem_d[wr_ptr] = '{kind: kind_e'(enq_kind), dst: enq_dst,
                              opa: enq_opa, opb: enq_opb};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign enq_ready  = ready;
    assign head_valid = st_q.valid[st_q.head];
    assign head_kind  = mem_q[st_q.head].kind;
    assign head_dst   = mem_q[st_q.head].dst;
    assign head_opa   = mem_q[st_q.head].opa;
    assign head_opb   = mem_q[st_q.head].opb;
    assign srch_hit   = hits[0];
    assign chk_stall  = hits[1] || ((kind_e'(chk_kind) != K_LD) && hits[2]);

    // R8: the count never exceeds the depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        st_q.count <= CNT_W'(DEPTH));

    // R6: a clear without an enqueue leaves nothing behind
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr && !enq_valid) |=> !head_valid && !srch_hit);

    // R7: clear with an enqueue leaves exactly one entry
    a_r7_clear_keeps_new: assert property (@(posedge clk) disable iff (rst)
        (clr && enq_valid) |=> (st_q.count == CNT_W'(1)) && head_valid);

    // R9: popping an empty queue with no push keeps it empty
    a_r9_empty_deq: assert property (@(posedge clk) disable iff (rst)
        (deq && !head_valid && !enq_valid) |=> !head_valid);

    // R4: a clear blinds the search in its own cycle
    a_r4_clear_blinds: assert property (@(posedge clk) disable iff (rst)
        clr |-> !srch_hit && !chk_stall);

    // R3: an empty queue never reports a pending writer
    a_r3_empty_no_hit: assert property (@(posedge clk) disable iff (rst)
        !head_valid |-> !srch_hit);
endmodule

// File: tb/sim_iq_scoreboard.sv
module sim_iq_scoreboard;
    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        enq_valid, deq, clr;
    logic [1:0]  enq_kind, chk_kind;
    logic [4:0]  enq_dst, srch_reg, chk_rs1, chk_rs2, head_dst;
    logic [31:0] enq_opa, enq_opb, head_opa, head_opb;
    logic        enq_ready, head_valid, srch_hit, chk_stall;
    logic [1:0]  head_kind;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    iq_scoreboard #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_dst(enq_dst),
        .enq_opa(enq_opa), .enq_opb(enq_opb), .enq_ready(enq_ready),
        .head_valid(head_valid), .head_kind(head_kind), .head_dst(head_dst),
        .head_opa(head_opa), .head_opb(head_opb),
        .deq(deq), .clr(clr), .srch_reg(srch_reg), .srch_hit(srch_hit),
        .chk_kind(chk_kind), .chk_rs1(chk_rs1), .chk_rs2(chk_rs2),
        .chk_stall(chk_stall)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at the falling edge, settle combinational outputs.
    task automatic cyc(input bit ev, input logic [1:0] k, input logic [4:0] d,
                       input logic [31:0] a, input logic [31:0] b,
                       input bit dq, input bit cl);
        @(negedge clk);
        enq_valid = ev; enq_kind = k; enq_dst = d; enq_opa = a; enq_opb = b;
        deq = dq; clr = cl;
        #1;
    endtask

    task automatic idle();
        cyc(1'b0, 2'd0, 5'd0, 32'd0, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic flush();
        cyc(1'b0, 2'd0, 5'd0, 32'd0, 32'd0, 1'b0, 1'b1);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] mq [$];
        rst = 1'b1; enq_valid = 0; deq = 0; clr = 0; enq_kind = 0; enq_dst = 0;
        enq_opa = 0; enq_opb = 0; srch_reg = 0; chk_kind = 0; chk_rs1 = 0; chk_rs2 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;

        // R1: reset state
        check("R1 head_valid", head_valid, 0);
        check("R1 enq_ready", enq_ready, 1);
        check("R1 srch_hit", srch_hit, 0);
        check("R1 chk_stall", chk_stall, 0);

        // R3: every kind against every register name, producer dst 5
        for (int k = 0; k < 4; k++) begin
            cyc(1'b1, 2'(k), 5'd5, 32'd1, 32'd2, 1'b0, 1'b0);
            idle();
            for (int r = 0; r < 32; r++) begin
                srch_reg = 5'(r); #1;
                check("R3 search", srch_hit, ((k == 0 || k == 2) && r == 5) ? 1 : 0);
            end
            flush();
        end

        // R5: stall sweep, producers of each kind writing dst 9
        for (int pk = 0; pk < 4; pk++) begin
            cyc(1'b1, 2'(pk), 5'd9, 32'd0, 32'd0, 1'b0, 1'b0);
            idle();
            for (int ck = 0; ck < 4; ck++) begin
                for (int m = 0; m < 4; m++) begin
                    bit e1, e2, pw;
                    e1 = m[0]; e2 = m[1];
                    pw = (pk == 0 || pk == 2);
                    chk_kind = 2'(ck);
                    chk_rs1 = e1 ? 5'd9 : 5'd3;
                    chk_rs2 = e2 ? 5'd9 : 5'd4;
                    #1;
                    check("R5 stall", chk_stall, (pw && (e1 || (ck != 2 && e2))) ? 1 : 0);
                end
            end
            flush();
        end
        chk_rs1 = 5'd0; chk_rs2 = 5'd0;

        // R4: same-cycle ordering
        idle();
        srch_reg = 5'd12;
        cyc(1'b1, 2'd0, 5'd12, 32'd0, 32'd0, 1'b0, 1'b0);
        check("R4 arriving entry unseen", srch_hit, 0);
        idle();
        check("R4 held entry seen", srch_hit, 1);
        cyc(1'b0, 2'd0, 5'd0, 32'd0, 32'd0, 1'b1, 1'b0);
        check("R4 departing entry unseen", srch_hit, 0);
        idle();
        check("R4 after dequeue", srch_hit, 0);
        cyc(1'b1, 2'd2, 5'd12, 32'd0, 32'd0, 1'b0, 1'b0);
        idle();
        cyc(1'b0, 2'd0, 5'd0, 32'd0, 32'd0, 1'b0, 1'b1);
        check("R4 clear blinds search", srch_hit, 0);
        idle();

        // R8/R10/R2: fill, drop, concurrent push-pop
        cyc(1'b1, 2'd0, 5'd1, 32'hA0, 32'hA1, 1'b0, 1'b0);
        cyc(1'b1, 2'd2, 5'd2, 32'hB0, 32'hB1, 1'b0, 1'b0);
        idle();
        check("R8 full not ready", enq_ready, 0);
        cyc(1'b1, 2'd3, 5'd3, 32'hC0, 32'hC1, 1'b0, 1'b0);
        check("R8 dropped offer not ready", enq_ready, 0);
        idle();
        check("R2 head A opa", head_opa, 32'hA0);
        cyc(1'b1, 2'd3, 5'd3, 32'hD0, 32'hD1, 1'b1, 1'b0);
        check("R8 ready with dequeue", enq_ready, 1);
        idle();
        check("R10 still full", enq_ready, 0);
        check("R10 head B kind", head_kind, 2);
        check("R10 head B dst", head_dst, 2);
        check("R10 head B opb", head_opb, 32'hB1);
        cyc(1'b0, 2'd0, 5'd0, 32'd0, 32'd0, 1'b1, 1'b0);
        idle();
        check("R8 C was dropped, head D", head_opa, 32'hD0);
        check("R2 head D kind", head_kind, 3);
        cyc(1'b0, 2'd0, 5'd0, 32'd0, 32'd0, 1'b1, 1'b0);
        idle();
        check("R2 drained", head_valid, 0);

        // R9: dequeue on empty
        cyc(1'b0, 2'd0, 5'd0, 32'd0, 32'd0, 1'b1, 1'b0);
        cyc(1'b1, 2'd0, 5'd7, 32'hE0, 32'hE1, 1'b1, 1'b0);
        idle();
        check("R9 entry survives empty dequeue", head_valid, 1);
        check("R9 head value", head_opa, 32'hE0);
        flush();

        // R6: clear a full queue
        cyc(1'b1, 2'd0, 5'd1, 32'd1, 32'd1, 1'b0, 1'b0);
        cyc(1'b1, 2'd2, 5'd2, 32'd2, 32'd2, 1'b0, 1'b0);
        flush();
        idle();
        check("R6 empty after clear", head_valid, 0);
        check("R6 ready after clear", enq_ready, 1);

        // R7: clear plus enqueue
        cyc(1'b1, 2'd0, 5'd1, 32'd1, 32'd1, 1'b0, 1'b0);
        cyc(1'b1, 2'd0, 5'd2, 32'd2, 32'd2, 1'b0, 1'b0);
        cyc(1'b1, 2'd2, 5'd8, 32'h77, 32'h78, 1'b0, 1'b1);
        idle();
        check("R7 new entry head", head_opa, 32'h77);
        check("R7 not full", enq_ready, 1);
        cyc(1'b0, 2'd0, 5'd0, 32'd0, 32'd0, 1'b1, 1'b0);
        idle();
        check("R7 only one entry", head_valid, 0);

        // R2: streaming order against a bench model
        for (int i = 0; i < 60; i++) begin
            bit ev, dq, acc;
            ev = (i % 3) != 2;
            dq = (i % 4) == 1 || (i % 4) == 2;
            @(negedge clk);
            enq_valid = ev; enq_kind = 2'd1; enq_dst = 5'd0;
            enq_opa = 32'(i * 7 + 3); enq_opb = 32'd0; deq = dq; clr = 1'b0;
            #1;
            if (mq.size() > 0) check("R2 stream head", head_opa, mq[0]);
            else check("R2 stream empty", head_valid, 0);
            acc = ev && (mq.size() < DEPTH || (dq && mq.size() > 0));
            check("R8 stream ready", enq_ready, (mq.size() < DEPTH || (dq && mq.size() > 0)) ? 1 : 0);
            if (dq && mq.size() > 0) void'(mq.pop_front());
            if (acc) mq.push_back(32'(i * 7 + 3));
        end
        idle();
        summary();
    end
endmodule